// File: doc/BRIEF.md
# Encrypted Code Read-Back and Lock Gate

This block sits between the test pins of a small controller and its 8K-byte code store when the code is read back for checking. A 13-bit verify address is built from an 8-bit low port and a 5-bit high field. It is passed to the store, and the byte that comes back is combined with one of 32 key bytes. The key is selected by the five lowest address bits. The combined byte is then driven out on the data port, one clock later, with an output enable.

Two lock fuses set how much is hidden. With neither fuse blown, read-back runs freely. The keys still apply, so a programmed key array scrambles the data. Blowing the first fuse stops table-read instructions that run from external code from fetching internal code bytes. Blowing both fuses also shuts read-back off completely. The level of the external-execution select pin is captured while reset is held and kept until the next reset.

The key array is a bank of registers loaded through a simple write port. It comes out of reset in the unprogrammed state, with every bit set to one.

Top module: `code_verify_guard`

## Requirements
- R1: `code_addr` equals `{vfy_addr_hi, vfy_addr_lo}` combinationally, and the key used for a read is the one whose index equals `code_addr[4:0]`.
- R2: One clock after a sampled cycle with `vfy_en`=1 and read-back not locked, `vfy_data` equals the bitwise XNOR of the `code_byte` and the selected key of that cycle, and `vfy_oe` is 1.
- R3: After reset every key byte is 8'hFF, so read-back returns the code byte unchanged.
- R4: A code byte of 8'hFF reads back as the selected key byte itself.
- R5: A clock edge with `key_we`=1 stores `key_din` in key entry `key_idx`; the new key is used by reads from the next cycle on.
- R6: One clock after a cycle with `vfy_en`=0, `vfy_oe` is 0 and `vfy_data` is 8'h00. Both are 0 in reset.
- R7: With `lock_a`=1, `tbl_rd_block` is 1 exactly when `tbl_rd_req`=1 and `exec_external`=1. Read-back still works as in R2.
- R8: With `lock_a`=1 and `lock_b`=1, `vfy_oe` stays 0 and `vfy_data` stays 8'h00 even while `vfy_en`=1.
- R9: With `lock_a`=0, `lock_b` has no effect: `tbl_rd_block` is 0, and read-back follows R2.
- R10: `ea_latched` takes the value of `ea_pin` on every clock edge while `rst_n`=0. After reset it holds that value regardless of `ea_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vfy_en | input | 1 | Verify read-back request |
| vfy_addr_lo | input | 8 | Low verify address byte |
| vfy_addr_hi | input | 5 | High verify address field |
| code_addr | output | 13 | Address to the code store |
| code_byte | input | 8 | Byte returned by the code store |
| key_we | input | 1 | Key array write strobe |
| key_idx | input | 5 | Key array write index |
| key_din | input | 8 | Key array write data |
| lock_a | input | 1 | First lock fuse, 1 = programmed |
| lock_b | input | 1 | Second lock fuse, 1 = programmed |
| ea_pin | input | 1 | External-execution select pin level |
| exec_external | input | 1 | Current instruction runs from external code |
| tbl_rd_req | input | 1 | Table read aimed at internal code |
| vfy_data | output | 8 | Read-back data byte |
| vfy_oe | output | 1 | Drive enable for the data port |
| tbl_rd_block | output | 1 | Table read refused |
| ea_latched | output | 1 | External-execution select captured at reset |

## Verification
A corrupted key entry shows up on the next read of any address whose low five bits select that entry. A full sweep of all 8192 addresses therefore reaches every entry 256 times, and a fault appears within 32 cycles of the sweep's start. A wrong lock decode shows on the enable in the cycle after the request, or on the table-read gate in the same cycle. A latched external-execution value that drifts is visible at once on its output pin.

// File: rtl/cvg_pkg.sv
// Shared types for the code verify guard.
// Assumes fuses read 1 when programmed.
package cvg_pkg;
    typedef enum logic [1:0] {
        PROT_OPEN    = 2'd0,  // no restriction
        PROT_NOTABLE = 2'd1,  // external table reads of internal code refused
        PROT_SEALED  = 2'd2   // additionally no read-back
    } prot_level_e;
endpackage

// File: rtl/cvg_key_bank.sv
// Key register bank: ENTRIES bytes, reset to all ones, one write port,
// one combinational read port. Assumes a single writer.
module cvg_key_bank #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [DATA_W-1:0] keys_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Hold one key byte; unprogrammed state is all ones.
        always_ff @(posedge clk) begin
            if (!rst_n)
                keys_q[g] <= '1;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                keys_q[g] <= wr_data;
        end
    end

    // Read port for the current verify address.
    assign rd_data = keys_q[rd_idx];

    // R5
    key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> keys_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/cvg_lock_ctrl.sv
// Lock decode, table-read gate and reset-time capture of the
// external-execution select. Assumes fuses are static in operation.
module cvg_lock_ctrl
    import cvg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_a,
    input  logic        lock_b,
    input  logic        ea_pin,
    input  logic        exec_external,
    input  logic        tbl_rd_req,
    output prot_level_e level,
    output logic        tbl_rd_block,
    output logic        ea_latched
);
    logic ea_q;

    // Map fuse pair to protection level; second fuse alone is inert.
    always_comb begin
        if (lock_a && lock_b)
            level = PROT_SEALED;
        else if (lock_a)
            level = PROT_NOTABLE;
        else
            level = PROT_OPEN;
    end

    // Refuse internal table reads issued from external code when locked.
    assign tbl_rd_block = (level != PROT_OPEN) && exec_external && tbl_rd_req;

    // Follow the pin while reset is held, freeze afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ea_q <= ea_pin;
    end
    assign ea_latched = ea_q;

    // R10
    ea_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(ea_latched));
    // R7
    tbl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_block |-> (exec_external && tbl_rd_req && lock_a));
    // R9
    open_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_a |-> !tbl_rd_block);
endmodule

// File: rtl/cvg_verify_path.sv
// Read-back datapath: XNOR of code and key, registered with its enable.
// Data is forced to zero whenever the enable is low.
module cvg_verify_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vfy_en,
    input  logic              sealed,
    input  logic [DATA_W-1:0] code_byte,
    input  logic [DATA_W-1:0] key_byte,
    output logic [DATA_W-1:0] vfy_data,
    output logic              vfy_oe
);
    logic              drive_d;
    logic [DATA_W-1:0] data_q;
    logic              oe_q;

    // Read-back allowed only when requested and not sealed.
    assign drive_d = vfy_en && !sealed;

    // Register the scrambled byte and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q   <= drive_d;
            data_q <= drive_d ? ~(code_byte ^ key_byte) : '0;
        end
    end

    assign vfy_data = data_q;
    assign vfy_oe   = oe_q;

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vfy_oe |-> (vfy_data == '0));
    // R8
    sealed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> !vfy_oe);
    // R2
    drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vfy_en && !sealed) |=> vfy_oe);
endmodule

// File: rtl/code_verify_guard.sv
// Top: encrypted code read-back and lock gate. Builds the store address,
// picks the key by the low address bits, applies the lock hierarchy.
// Assumes the code store answers combinationally on code_byte.
module code_verify_guard
    import cvg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ALO_W   = 8,
    parameter int AHI_W   = 5,
    parameter int KIDX_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vfy_en,
    input  logic [ALO_W-1:0]         vfy_addr_lo,
    input  logic [AHI_W-1:0]         vfy_addr_hi,
    output logic [ALO_W+AHI_W-1:0]   code_addr,
    input  logic [DATA_W-1:0]        code_byte,
    input  logic                     key_we,
    input  logic [KIDX_W-1:0]        key_idx,
    input  logic [DATA_W-1:0]        key_din,
    input  logic                     lock_a,
    input  logic                     lock_b,
    input  logic                     ea_pin,
    input  logic                     exec_external,
    input  logic                     tbl_rd_req,
    output logic [DATA_W-1:0]        vfy_data,
    output logic                     vfy_oe,
    output logic                     tbl_rd_block,
    output logic                     ea_latched
);
    logic [DATA_W-1:0] key_byte;
    prot_level_e       level;

    // Concatenate the two address fields for the store.
    assign code_addr = {vfy_addr_hi, vfy_addr_lo};

    cvg_key_bank #(.DATA_W(DATA_W), .IDX_W(KIDX_W)) u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (key_we),
        .wr_idx  (key_idx),
        .wr_data (key_din),
        .rd_idx  (code_addr[KIDX_W-1:0]),
        .rd_data (key_byte)
    );

    cvg_lock_ctrl u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .lock_a        (lock_a),
        .lock_b        (lock_b),
        .ea_pin        (ea_pin),
        .exec_external (exec_external),
        .tbl_rd_req    (tbl_rd_req),
        .level         (level),
        .tbl_rd_block  (tbl_rd_block),
        .ea_latched    (ea_latched)
    );

    cvg_verify_path #(.DATA_W(DATA_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .vfy_en    (vfy_en),
        .sealed    (level == PROT_SEALED),
        .code_byte (code_byte),
        .key_byte  (key_byte),
        .vfy_data  (vfy_data),
        .vfy_oe    (vfy_oe)
    );

    // R8
    fuse_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_a && lock_b) |=> (!vfy_oe && vfy_data == '0));
endmodule

// File: tb/code_verify_guard_tb.sv
module code_verify_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vfy_en;
    logic [7:0]  vfy_addr_lo;
    logic [4:0]  vfy_addr_hi;
    logic [12:0] code_addr;
    logic [7:0]  code_byte;
    logic        key_we;
    logic [4:0]  key_idx;
    logic [7:0]  key_din;
    logic        lock_a, lock_b, ea_pin, exec_external, tbl_rd_req;
    logic [7:0]  vfy_data;
    logic        vfy_oe, tbl_rd_block, ea_latched;
    logic        force_ff;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    code_verify_guard u_dut (
        .clk(clk), .rst_n(rst_n), .vfy_en(vfy_en),
        .vfy_addr_lo(vfy_addr_lo), .vfy_addr_hi(vfy_addr_hi),
        .code_addr(code_addr), .code_byte(code_byte),
        .key_we(key_we), .key_idx(key_idx), .key_din(key_din),
        .lock_a(lock_a), .lock_b(lock_b), .ea_pin(ea_pin),
        .exec_external(exec_external), .tbl_rd_req(tbl_rd_req),
        .vfy_data(vfy_data), .vfy_oe(vfy_oe),
        .tbl_rd_block(tbl_rd_block), .ea_latched(ea_latched)
    );

    function automatic logic [7:0] code_of(input logic [12:0] a);
        return 8'((a[7:0] * 13) + (a[12:8] * 7) + 3);
    endfunction
    function automatic logic [7:0] key_of(input logic [4:0] i);
        return 8'(i * 37 + 5);
    endfunction

    // Bench model of the code store.
    always_comb code_byte = force_ff ? 8'hFF : code_of(code_addr);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one address, clock it, sample after the edge.
    task automatic read_at(input logic [12:0] a);
        @(negedge clk);
        vfy_en = 1'b1;
        {vfy_addr_hi, vfy_addr_lo} = a;
        #1;
        check(code_addr == a, "R1", code_addr, a);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; vfy_en = 0; vfy_addr_lo = 0; vfy_addr_hi = 0;
        key_we = 0; key_idx = 0; key_din = 0; lock_a = 0; lock_b = 0;
        ea_pin = 0; exec_external = 0; tbl_rd_req = 0; force_ff = 0;
        repeat (3) @(posedge clk);
        #1;
        check(vfy_oe == 0 && vfy_data == 0, "R6", vfy_data, 0);
        check(ea_latched == 0, "R10", ea_latched, 0);
        @(negedge clk); rst_n = 1; ea_pin = 1;
        repeat (3) @(posedge clk);
        #1;
        check(ea_latched == 0, "R10", ea_latched, 0);

        // R3: unprogrammed keys pass code through, full sweep
        for (int a = 0; a < 8192; a++) begin
            read_at(13'(a));
            check(vfy_oe && vfy_data == code_of(13'(a)), "R3", vfy_data, code_of(13'(a)));
        end

        // R6: idle output
        @(negedge clk); vfy_en = 0;
        @(posedge clk); #1;
        check(!vfy_oe && vfy_data == 0, "R6", vfy_data, 0);

        // R5: program all keys
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            key_we = 1; key_idx = 5'(i); key_din = key_of(5'(i));
        end
        @(negedge clk); key_we = 0;

        // R2: scrambled sweep
        for (int a = 0; a < 8192; a++) begin
            read_at(13'(a));
            check(vfy_oe && vfy_data == ~(code_of(13'(a)) ^ key_of(a[4:0])),
                  "R2", vfy_data, ~(code_of(13'(a)) ^ key_of(a[4:0])));
        end

        // R4: FF code reveals key
        force_ff = 1;
        for (int i = 0; i < 32; i++) begin
            read_at(13'(i + 64));
            check(vfy_data == key_of(5'(i)), "R4", vfy_data, key_of(5'(i)));
        end
        force_ff = 0;

        // R9: second fuse alone inert
        lock_b = 1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); exec_external = c[0]; tbl_rd_req = c[1]; #1;
            check(tbl_rd_block == 0, "R9", tbl_rd_block, 0);
        end
        read_at(13'h1234);
        check(vfy_oe && vfy_data == ~(code_of(13'h1234) ^ key_of(5'h14)), "R9",
              vfy_data, ~(code_of(13'h1234) ^ key_of(5'h14)));

        // R7: first fuse only
        lock_b = 0; lock_a = 1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); exec_external = c[0]; tbl_rd_req = c[1]; #1;
            check(tbl_rd_block == (c == 3), "R7", tbl_rd_block, (c == 3));
        end
        read_at(13'h0A5F);
        check(vfy_oe && vfy_data == ~(code_of(13'h0A5F) ^ key_of(5'h1F)), "R7",
              vfy_data, ~(code_of(13'h0A5F) ^ key_of(5'h1F)));

        // R8: both fuses seal read-back
        lock_b = 1;
        for (int a = 0; a < 64; a++) begin
            read_at(13'(a * 97));
            check(!vfy_oe && vfy_data == 0, "R8", vfy_data, 0);
        end
        @(negedge clk); exec_external = 1; tbl_rd_req = 1; #1;
        check(tbl_rd_block == 1, "R7", tbl_rd_block, 1);

        // R10: recapture with the pin high
        @(negedge clk); rst_n = 0; ea_pin = 1; lock_a = 0; lock_b = 0;
        @(posedge clk); #1;
        @(negedge clk); rst_n = 1; ea_pin = 0;
        repeat (2) @(posedge clk); #1;
        check(ea_latched == 1, "R10", ea_latched, 1);
        // R3 again: keys back to all ones after reset
        read_at(13'h0007);
        check(vfy_data == code_of(13'h0007), "R3", vfy_data, code_of(13'h0007));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule